// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a virtual address that missed in a translation cache. It reads two page table entries from memory, one per level, and returns either a physical address or a page-fault flag. The virtual address is split into fixed fields:

- bits 31:22 select the level-1 entry;
- bits 21:12 select the level-2 entry;
- bits 11:0 are the offset within the page.

Supervisor software keeps the base of the current level-1 table in a root register, and the block takes that value on an input. A walk opens with a one-cycle `start` while the block is idle. The block issues single-cycle read requests on a simple memory port and waits as long as needed for each response. It closes the walk with a one-cycle `done`.

Each entry is a 32-bit word with these fields:

- bit 0 marks the page as existing;
- bit 1 marks it as resident in primary memory;
- bits 31:12 hold the page number.

When the page is resident, the page number is a physical page. When the page is held on disk, the page number is a disk page. An entry that is missing or not resident, at either level, ends the walk with a fault. Only one walk is in flight at a time.

Top module: `pt_walker`

## Requirements
- R1: After reset the block is idle: `busy`, `mem_req`, `done` and `fault` are low and `paddr` is zero.
- R2: One cycle after `start` is taken in idle, `mem_req` is high for exactly one cycle with `mem_addr` = root + 4 × vaddr[31:22].
- R3: Entries are decoded as bit 0 = exists, bit 1 = resident, bits 31:12 = page number. After a good level-1 entry, a second one-cycle request is issued at (level-1 page number << 12) + 4 × vaddr[21:12].
- R4: A level-1 entry with bit 0 or bit 1 clear ends the walk with `fault` high, and no second request is made.
- R5: A level-2 entry with bit 0 or bit 1 clear ends the walk with `fault` high.
- R6: On success, `paddr` = {level-2 page number, vaddr[11:0]} and `fault` is low. Entry bits 11:2 have no effect.
- R7: `done` is high for exactly one cycle per walk. While `fault` is high, `paddr` is zero, and `fault` is never high without `done`.
- R8: `start`, `vaddr` and `root` are ignored while a walk is in progress. The walk completes with the operands taken at acceptance.
- R9: The block waits any number of cycles for `mem_rvalid`. A `mem_rvalid` that arrives while no read is awaited has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| vaddr | input | 32 | Virtual address to translate |
| root | input | 32 | Base address of the level-1 table |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Read address, valid with `mem_req` |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data (entry word) |
| done | output | 1 | One-cycle walk completion |
| fault | output | 1 | Walk ended in a page fault (with `done`) |
| paddr | output | 32 | Translated address (with `done`, zero on fault) |

## Verification
The assertions assume that the memory returns exactly one `mem_rvalid` for each request, and never in the same cycle as the request itself. The assertions on fault timing read `mem_rdata` only when `mem_rvalid` arrives in a wait state.

The stimulus respects these assumptions. The bench answers each request one to five cycles after it. It raises `mem_rvalid` in idle only in the directed test that shows such a response is ignored. It pulses `start` during a walk only while a response is still pending.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] vaddr,
  input  logic [31:0] root,
  output logic        busy,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        done,
  output logic        fault,
  output logic [31:0] paddr
);
  localparam int OFFW = 12;
  localparam int IDXW = 10;
  localparam int PNW  = 32 - OFFW;

  typedef enum logic [2:0] {IDLE, READ_L1, WAIT_L1, READ_L2, WAIT_L2, DONE} st_t;

  st_t             st;
  logic [31:0]     va_q, root_q;
  logic [PNW-1:0]  pn_q;
  logic            flt_q;

  wire pte_ok = mem_rdata[0] & mem_rdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      va_q   <= '0;
      root_q <= '0;
      pn_q   <= '0;
      flt_q  <= 1'b0;
    end else begin
      case (st)
        IDLE: if (start) begin
          va_q   <= vaddr;
          root_q <= root;
          flt_q  <= 1'b0;
          st     <= READ_L1;
        end
        READ_L1: st <= WAIT_L1;
        WAIT_L1: if (mem_rvalid) begin
          pn_q <= mem_rdata[31:OFFW];
          if (pte_ok) st <= READ_L2;
          else begin
            flt_q <= 1'b1;
            st    <= DONE;
          end
        end
        READ_L2: st <= WAIT_L2;
        WAIT_L2: if (mem_rvalid) begin
          pn_q  <= mem_rdata[31:OFFW];
          flt_q <= ~pte_ok;
          st    <= DONE;
        end
        DONE:    st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  wire [IDXW-1:0] p1 = va_q[31:OFFW+IDXW];
  wire [IDXW-1:0] p2 = va_q[OFFW+IDXW-1:OFFW];

  assign busy     = (st != IDLE);
  assign mem_req  = (st == READ_L1) || (st == READ_L2);
  assign mem_addr = (st == READ_L2) ? {pn_q, p2, 2'b00}
                                    : root_q + {{(30-IDXW){1'b0}}, p1, 2'b00};
  assign done     = (st == DONE);
  assign fault    = done & flt_q;
  assign paddr    = (done & ~flt_q) ? {pn_q, va_q[OFFW-1:0]} : '0;

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  fault_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (done && paddr == '0));

  // R2
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R4
  l1_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WAIT_L1 && mem_rvalid && !pte_ok) |=> (done && fault));

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> ($stable(va_q) && $stable(root_q)));

  // R9
  stray_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start && mem_rvalid) |=> !busy);
endmodule

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] vaddr = '0, root = '0;
  logic        busy, mem_req, done, fault;
  logic [31:0] mem_addr, paddr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  pt_walker u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .vaddr(vaddr), .root(root),
    .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .done(done), .fault(fault), .paddr(paddr)
  );

  typedef struct packed {
    logic [31:0] va;
    logic [31:0] rt;
    logic [31:0] pte1;
    logic [31:0] pte2;
    logic [31:0] pa;
    logic        flt;
    logic [2:0]  lat;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{32'h0040_3ABC, 32'h0001_0000, 32'h0002_0003, 32'h1234_5003, 32'h1234_5ABC, 1'b0, 3'd1},
    '{32'hFFFF_FFFF, 32'h0008_0000, 32'h0030_0003, 32'hABCD_E003, 32'hABCD_EFFF, 1'b0, 3'd3},
    '{32'h0000_0000, 32'h0000_1000, 32'h0000_0002, 32'h1111_1003, 32'h0000_0000, 1'b1, 3'd2},
    '{32'h00C0_0123, 32'h0000_2000, 32'h0055_5001, 32'h2222_2003, 32'h0000_0000, 1'b1, 3'd1},
    '{32'h0080_1456, 32'h0000_3000, 32'h0004_0003, 32'h7777_7000, 32'h0000_0000, 1'b1, 3'd4},
    '{32'h1234_5678, 32'h0000_0000, 32'h0000_5003, 32'h0009_9001, 32'h0000_0000, 1'b1, 3'd5},
    '{32'h0000_1FFF, 32'h0000_4000, 32'h0001_0FF3, 32'h0ABC_DFFF, 32'h0ABC_DFFF, 1'b0, 3'd2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic walk(input vec_t v, input bit poke);
    int guard = 0;
    int reqs = 0;
    bit seen = 0;
    logic [31:0] l1a, l2a, data;
    bit l1ok;
    l1a  = v.rt + {20'b0, v.va[31:22], 2'b00};
    l2a  = {v.pte1[31:12], v.va[21:12], 2'b00};
    l1ok = v.pte1[0] & v.pte1[1];
    @(negedge clk);
    vaddr = v.va; root = v.rt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!seen && guard < 100) begin
      if (mem_req) begin
        reqs++;
        if (reqs == 1) chk("R2 level-1 address", mem_addr, l1a);
        else           chk("R3 level-2 address", mem_addr, l2a);
        data = (reqs == 1) ? v.pte1 : v.pte2;
        @(negedge clk);
        chk("R2 request one cycle", {31'b0, mem_req}, 32'd0);
        if (poke && reqs == 1) begin
          start = 1'b1; vaddr = ~v.va; root = 32'hDEAD_0000;
        end
        for (int k = 1; k < v.lat; k++) begin
          @(negedge clk);
          start = 1'b0;
        end
        mem_rvalid = 1'b1; mem_rdata = data;
        @(negedge clk);
        mem_rvalid = 1'b0; mem_rdata = '0; start = 1'b0;
      end else if (done) begin
        seen = 1;
        chk(v.flt ? (l1ok ? "R5 fault flag" : "R4 fault flag") : "R6 fault low",
            {31'b0, fault}, {31'b0, v.flt});
        chk(v.flt ? "R7 paddr zero on fault" : "R6 physical address", paddr, v.pa);
        chk(l1ok ? "R3 two reads" : "R4 single read", reqs, l1ok ? 32'd2 : 32'd1);
        @(negedge clk);
        chk("R7 done one cycle", {31'b0, done}, 32'd0);
        chk("R7 fault only with done", {31'b0, fault}, 32'd0);
      end else begin
        @(negedge clk);
        guard++;
      end
    end
    if (!seen) begin
      nchk++; nerr++;
      $display("FAIL R9 walk never completed actual=no-done expected=done");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", {31'b0, busy}, 32'd0);
    chk("R1 mem_req", {31'b0, mem_req}, 32'd0);
    chk("R1 done", {31'b0, done}, 32'd0);
    chk("R1 fault", {31'b0, fault}, 32'd0);
    chk("R1 paddr", paddr, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) walk(VEC[i], 1'b0);

    // R8 start during a walk has no effect on the result
    walk(VEC[0], 1'b1);
    walk(VEC[4], 1'b1);

    // R9 stray response while idle is ignored
    @(negedge clk);
    mem_rvalid = 1'b1; mem_rdata = 32'hFFFF_FFFF;
    repeat (2) @(negedge clk);
    mem_rvalid = 1'b0; mem_rdata = '0;
    chk("R9 idle after stray rvalid", {31'b0, busy}, 32'd0);
    chk("R9 no done after stray rvalid", {31'b0, done}, 32'd0);
    chk("R9 no request after stray rvalid", {31'b0, mem_req}, 32'd0);
    walk(VEC[1], 1'b0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule